// File: doc/BRIEF.md
# Proportional-Integral Loop Filter with Slip Boost

This block is the digital loop filter of a clock-multiplying control loop. Its inputs come from a bang-bang phase detector: a strobe for each completed comparison, a one-bit late/early decision, and two cycle-slip flags. One flag means the reference is running faster than the feedback clock, and the other means the feedback clock is the faster one. From these inputs the filter keeps an integral state and a proportional term. It sums both around the mid-scale code and produces an unsigned control word for the oscillator.

The integral path accumulates the bang-bang decisions. After lock it holds the frequency setting. The proportional path skips the integrator and acts on the output directly.

Slip flags are added into the integrator with their own gain, which is normally far larger than the bang-bang step. While the loop is far from the target frequency, the slip flags move the frequency quickly toward it. Once the two clocks run at the same rate, the slip flags stop, and only the bang-bang terms remain.

All three gains are given as power-of-two shift amounts. The integrator saturates instead of wrapping, and the output word is clamped to its code range.

Top module: `pi_slip_filter`

## Requirements
- R1: While reset is held, and after it is released until the first strobe, the integrator reads 0 and the control word reads mid-scale, 2^(CTRL_W-1) (512 by default).
- R2: In a cycle with `cmp_vld` low, the integrator and the control word keep their values, even if the gain inputs change.
- R3: On a strobe with no slip flag, the integrator changes by +2^`ki_sh` when `fb_late`=1 and by -2^`ki_sh` when `fb_late`=0.
- R4: On each strobe, the proportional term is set to +2^`kp_sh` (when `fb_late`=1) or -2^`kp_sh` (when `fb_late`=0). The control word is then clamp(2^(CTRL_W-1) + integrator + proportional term).
- R5: On a strobe, `ref_fast`=1 alone adds +2^`ks_sh` to the integrator and `fb_fast`=1 alone adds -2^`ks_sh`. Both flags together cancel. This adds to the R3 step.
- R6: The integrator saturates at 2^(INT_W-1)-1 and at -2^(INT_W-1). It never wraps.
- R7: The control word is clamped to the range 0 to 2^CTRL_W-1.
- R8: Slip flags and the decision bit seen while `cmp_vld` is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmp_vld | input | 1 | One-cycle strobe per detector comparison |
| fb_late | input | 1 | 1: feedback lags, speed up; 0: feedback leads, slow down |
| ref_fast | input | 1 | Cycle slip seen with the reference faster |
| fb_fast | input | 1 | Cycle slip seen with the feedback faster |
| kp_sh | input | SHIFT_W | Proportional gain shift |
| ki_sh | input | SHIFT_W | Integral gain shift |
| ks_sh | input | SHIFT_W | Slip gain shift |
| dco_ctrl | output | CTRL_W | Unsigned oscillator control word |
| integ_q | output | INT_W | Signed integrator state |

## Verification
Both the integrator and the proportional term are registers. The control word is combinational from those registers. A strobe present at a rising edge is therefore seen on both outputs right after that same edge.

The bench drives every input on the falling edge and holds the strobe for exactly one rising edge. It samples the outputs on the next falling edge, so each result is compared one half period after the edge that produced it. After reset is released, two extra edges pass through the reset synchronizer. The bench waits for those edges before it sends the first strobe.

// File: rtl/pi_filt_pkg.sv
package pi_filt_pkg;
  typedef enum logic [1:0] {
    SLIP_NONE = 2'b00,
    SLIP_UP   = 2'b01,
    SLIP_DN   = 2'b10
  } slip_dir_e;

  // Width that holds any sum of state, shifted gains and mid-scale.
  function automatic int ext_width(input int int_w, input int ctrl_w, input int shift_w);
    int base;
    base = (int_w > ctrl_w) ? int_w : ctrl_w;
    return base + (1 << shift_w) + 3;
  endfunction
endpackage

// File: rtl/pif_rst_sync.sv
module pif_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/pif_integ.sv
module pif_integ
  import pi_filt_pkg::*;
#(
  parameter int INT_W   = 16,
  parameter int SHIFT_W = 4,
  parameter int EXT_W   = 36
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    up,
  input  logic                    rf,
  input  logic                    ff,
  input  logic [SHIFT_W-1:0]      ki_sh,
  input  logic [SHIFT_W-1:0]      ks_sh,
  output logic signed [INT_W-1:0] integ_q
);
  localparam logic signed [EXT_W-1:0] IMAX = {{(EXT_W-INT_W+1){1'b0}}, {(INT_W-1){1'b1}}};
  localparam logic signed [EXT_W-1:0] IMIN = {{(EXT_W-INT_W+1){1'b1}}, {(INT_W-1){1'b0}}};
  localparam logic signed [EXT_W-1:0] ONE  = {{(EXT_W-1){1'b0}}, 1'b1};

  slip_dir_e                 slip_dir;
  logic signed [EXT_W-1:0]   bb_step, slip_step, cur_ext, sum_ext, sat_ext;
  logic signed [INT_W-1:0]   integ_d;

  always_comb begin
    unique case ({ff, rf})
      2'b01:   slip_dir = SLIP_UP;
      2'b10:   slip_dir = SLIP_DN;
      default: slip_dir = SLIP_NONE;
    endcase
  end

  always_comb begin
    bb_step = up ? (ONE <<< ki_sh) : -(ONE <<< ki_sh);
    unique case (slip_dir)
      SLIP_UP: slip_step = ONE <<< ks_sh;
      SLIP_DN: slip_step = -(ONE <<< ks_sh);
      default: slip_step = '0;
    endcase
    cur_ext = {{(EXT_W-INT_W){integ_q[INT_W-1]}}, integ_q};
    sum_ext = cur_ext + bb_step + slip_step;
    if (sum_ext > IMAX)      sat_ext = IMAX;
    else if (sum_ext < IMIN) sat_ext = IMIN;
    else                     sat_ext = sum_ext;
    integ_d = en ? sat_ext[INT_W-1:0] : integ_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) integ_q <= '0;
    else        integ_q <= integ_d;
  end
endmodule

// File: rtl/pif_prop.sv
module pif_prop #(
  parameter int SHIFT_W = 4,
  parameter int PW      = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 up,
  input  logic [SHIFT_W-1:0]   kp_sh,
  output logic signed [PW-1:0] prop_q
);
  localparam logic signed [PW-1:0] ONE = {{(PW-1){1'b0}}, 1'b1};

  logic signed [PW-1:0] prop_d;

  always_comb begin
    if (en) prop_d = up ? (ONE <<< kp_sh) : -(ONE <<< kp_sh);
    else    prop_d = prop_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prop_q <= '0;
    else        prop_q <= prop_d;
  end
endmodule

// File: rtl/pif_clamp.sv
module pif_clamp #(
  parameter int INT_W  = 16,
  parameter int PW     = 18,
  parameter int CTRL_W = 10,
  parameter int EXT_W  = 36
) (
  input  logic signed [INT_W-1:0] integ,
  input  logic signed [PW-1:0]    prop,
  output logic [CTRL_W-1:0]       ctrl
);
  localparam logic signed [EXT_W-1:0] ONE  = {{(EXT_W-1){1'b0}}, 1'b1};
  localparam logic signed [EXT_W-1:0] MID  = ONE <<< (CTRL_W-1);
  localparam logic signed [EXT_W-1:0] CMAX = {{(EXT_W-CTRL_W){1'b0}}, {CTRL_W{1'b1}}};

  logic signed [EXT_W-1:0] sum_ext;

  always_comb begin
    sum_ext = MID
            + {{(EXT_W-INT_W){integ[INT_W-1]}}, integ}
            + {{(EXT_W-PW){prop[PW-1]}}, prop};
    if (sum_ext[EXT_W-1])   ctrl = '0;
    else if (sum_ext > CMAX) ctrl = '1;
    else                     ctrl = sum_ext[CTRL_W-1:0];
  end
endmodule

// File: rtl/pi_slip_filter.sv
module pi_slip_filter
  import pi_filt_pkg::*;
#(
  parameter int INT_W   = 16,
  parameter int CTRL_W  = 10,
  parameter int SHIFT_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmp_vld,
  input  logic                    fb_late,
  input  logic                    ref_fast,
  input  logic                    fb_fast,
  input  logic [SHIFT_W-1:0]      kp_sh,
  input  logic [SHIFT_W-1:0]      ki_sh,
  input  logic [SHIFT_W-1:0]      ks_sh,
  output logic [CTRL_W-1:0]       dco_ctrl,
  output logic signed [INT_W-1:0] integ_q
);
  localparam int EXT_W = ext_width(INT_W, CTRL_W, SHIFT_W);
  localparam int PW    = (1 << SHIFT_W) + 2;

  logic                 rst_s_n;
  logic signed [PW-1:0] prop_q;

  pif_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  pif_integ #(.INT_W(INT_W), .SHIFT_W(SHIFT_W), .EXT_W(EXT_W)) u_integ (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .en      (cmp_vld),
    .up      (fb_late),
    .rf      (ref_fast),
    .ff      (fb_fast),
    .ki_sh   (ki_sh),
    .ks_sh   (ks_sh),
    .integ_q (integ_q)
  );

  pif_prop #(.SHIFT_W(SHIFT_W), .PW(PW)) u_prop (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .en     (cmp_vld),
    .up     (fb_late),
    .kp_sh  (kp_sh),
    .prop_q (prop_q)
  );

  pif_clamp #(.INT_W(INT_W), .PW(PW), .CTRL_W(CTRL_W), .EXT_W(EXT_W)) u_clamp (
    .integ (integ_q),
    .prop  (prop_q),
    .ctrl  (dco_ctrl)
  );
endmodule

// File: rtl/pi_slip_filter_chk.sv
module pi_slip_filter_chk #(
  parameter int INT_W   = 16,
  parameter int CTRL_W  = 10,
  parameter int SHIFT_W = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cmp_vld,
  input logic                    fb_late,
  input logic                    ref_fast,
  input logic                    fb_fast,
  input logic [SHIFT_W-1:0]      ki_sh,
  input logic [SHIFT_W-1:0]      ks_sh,
  input logic [CTRL_W-1:0]       dco_ctrl,
  input logic signed [INT_W-1:0] integ_q
);
  localparam longint IMAX = (64'sd1 <<< (INT_W-1)) - 1;
  localparam longint IMIN = -(64'sd1 <<< (INT_W-1));

  longint i_now, istep, sstep;
  assign i_now = longint'(integ_q);
  assign istep = 64'sd1 <<< ki_sh;
  assign sstep = 64'sd1 <<< ks_sh;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_vld |=> $stable(integ_q) && $stable(dco_ctrl));

  assert_bb_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_vld && fb_late && !ref_fast && !fb_fast && (i_now + istep <= IMAX)
    |=> i_now == $past(i_now) + $past(istep));

  assert_slip_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_vld && fb_late && ref_fast && !fb_fast && (i_now + istep + sstep <= IMAX)
    |=> i_now == $past(i_now) + $past(istep) + $past(sstep));

  assert_slip_dn_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_vld && !fb_late && fb_fast && !ref_fast && (i_now - istep - sstep >= IMIN)
    |=> i_now == $past(i_now) - $past(istep) - $past(sstep));

  assert_sat_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_vld && fb_late && !fb_fast && (i_now == IMAX) |=> i_now == IMAX);

  assert_sat_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_vld && !fb_late && !ref_fast && (i_now == IMIN) |=> i_now == IMIN);
endmodule

bind pi_slip_filter pi_slip_filter_chk #(
  .INT_W(INT_W), .CTRL_W(CTRL_W), .SHIFT_W(SHIFT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_s_n),
  .cmp_vld  (cmp_vld),
  .fb_late  (fb_late),
  .ref_fast (ref_fast),
  .fb_fast  (fb_fast),
  .ki_sh    (ki_sh),
  .ks_sh    (ks_sh),
  .dco_ctrl (dco_ctrl),
  .integ_q  (integ_q)
);

// File: tb/test_pi_slip_filter.sv
module test_pi_slip_filter;
  localparam int INT_W = 16, CTRL_W = 10, SHIFT_W = 4;
  localparam longint IMAX = 32767, IMIN = -32768, MID = 512, CMAX = 1023;

  logic clk, rst_n, cmp_vld, fb_late, ref_fast, fb_fast;
  logic [SHIFT_W-1:0] kp_sh, ki_sh, ks_sh;
  logic [CTRL_W-1:0] dco_ctrl;
  logic signed [INT_W-1:0] integ_q;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  longint m_int = 0, m_prop = 0;

  pi_slip_filter #(.INT_W(INT_W), .CTRL_W(CTRL_W), .SHIFT_W(SHIFT_W)) i_pi_slip_filter (
    .clk(clk), .rst_n(rst_n), .cmp_vld(cmp_vld), .fb_late(fb_late),
    .ref_fast(ref_fast), .fb_fast(fb_fast), .kp_sh(kp_sh), .ki_sh(ki_sh),
    .ks_sh(ks_sh), .dco_ctrl(dco_ctrl), .integ_q(integ_q));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {strobe, late, ref_fast, fb_fast, kp[3:0], ki[3:0], ks[3:0]}
  localparam logic [15:0] VEC [12] = '{
    {4'b1100, 4'd2, 4'd0, 4'd6},
    {4'b1000, 4'd2, 4'd0, 4'd6},
    {4'b1110, 4'd0, 4'd1, 4'd6},
    {4'b0110, 4'd0, 4'd1, 4'd6},
    {4'b1001, 4'd3, 4'd2, 4'd4},
    {4'b1111, 4'd1, 4'd0, 4'd8},
    {4'b0001, 4'd1, 4'd0, 4'd8},
    {4'b1100, 4'd5, 4'd3, 4'd0},
    {4'b1000, 4'd5, 4'd3, 4'd0},
    {4'b1110, 4'd0, 4'd0, 4'd9},
    {4'b1001, 4'd0, 4'd0, 4'd9},
    {4'b0100, 4'd15, 4'd15, 4'd15}
  };

  function automatic longint clampc(input longint v);
    if (v < 0) return 0;
    if (v > CMAX) return CMAX;
    return v;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input bit stb, input bit lt, input bit rf, input bit ff,
                      input int kp, input int ki, input int ks, input string req);
    longint s;
    @(negedge clk);
    cmp_vld = stb; fb_late = lt; ref_fast = rf; fb_fast = ff;
    kp_sh = SHIFT_W'(kp); ki_sh = SHIFT_W'(ki); ks_sh = SHIFT_W'(ks);
    @(negedge clk);
    cmp_vld = 1'b0;
    if (stb) begin
      s = m_int + (lt ? (64'sd1 << ki) : -(64'sd1 << ki));
      if (rf && !ff) s = s + (64'sd1 << ks);
      if (ff && !rf) s = s - (64'sd1 << ks);
      m_int  = (s > IMAX) ? IMAX : ((s < IMIN) ? IMIN : s);
      m_prop = lt ? (64'sd1 << kp) : -(64'sd1 << kp);
    end
    check(req, longint'(integ_q), m_int);
    check("R4/R7 ctrl", longint'(dco_ctrl), clampc(MID + m_int + m_prop));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 integ in reset", longint'(integ_q), 0);
    check("R1 ctrl in reset", longint'(dco_ctrl), MID);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_int = 0; m_prop = 0;
    check("R1 ctrl after release", longint'(dco_ctrl), MID);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmp_vld = 0; fb_late = 0; ref_fast = 0; fb_fast = 0;
    kp_sh = '0; ki_sh = '0; ks_sh = '0;
    repeat (3) @(negedge clk);
    check("R1 integ in reset", longint'(integ_q), 0);
    check("R1 ctrl in reset", longint'(dco_ctrl), MID);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    foreach (VEC[i]) begin
      logic [15:0] v;
      string req;
      v = VEC[i];
      if (!v[15])              req = (v[13] | v[12]) ? "R8 ignored flags" : "R2 hold";
      else if (v[13] | v[12])  req = "R5 slip";
      else                     req = "R3 bang-bang";
      step(v[15], v[14], v[13], v[12], int'(v[11:8]), int'(v[7:4]), int'(v[3:0]), req);
    end

    // R6: drive integrator to positive limit with large slip gain
    for (int k = 0; k < 3; k++) step(1, 1, 1, 0, 0, 0, 15, "R6 sat max");
    check("R6 at max", longint'(integ_q), IMAX);
    check("R7 clamp high", longint'(dco_ctrl), CMAX);
    step(1, 1, 0, 0, 0, 15, 0, "R6 no wrap up");
    // R6: negative limit
    for (int k = 0; k < 3; k++) step(1, 0, 0, 1, 0, 0, 15, "R6 sat min");
    check("R6 at min", longint'(integ_q), IMIN);
    check("R7 clamp low", longint'(dco_ctrl), 0);
    step(1, 0, 0, 0, 0, 15, 0, "R6 no wrap down");
    // R8: flags without strobe at a limit
    step(0, 1, 1, 0, 0, 0, 15, "R8 ignored flags");
    // R5: both flags cancel
    step(1, 1, 1, 1, 0, 0, 15, "R5 cancel");
    // R1: reset mid-run
    do_reset();
    step(1, 1, 0, 0, 4, 2, 0, "R3 after reset");
    step(1, 0, 1, 0, 4, 2, 3, "R5 ref_fast with early");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule